// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the external pin timing of an 8-bit processor whose low address byte and data byte share one set of pins. A requester presents a cycle kind, a 16-bit address, a write byte and a flag that picks the long form of an opcode fetch. While the sequencer is idle it takes the request and steps through the T-states of that cycle. It drives the multiplexed bus through a separate output value and output enable, the high address byte, an address latch strobe, active-low read and write strobes, a memory/IO select and two status bits. When a read finishes it returns the captured byte together with a one-clock done pulse.

Each T-state lasts one clock period and starts on the falling clock edge. The address latch strobe is raised at the start of T1 and dropped on the rising edge in the middle of T1, so the block uses both clock edges. An external latch can therefore catch the low address byte before the same pins carry data.

Top module: `bus_cycle_seq`

## Requirements
- R1: A request is taken on a falling edge only while the sequencer is idle. A request made during a running cycle, or one with a kind code of 5, 6 or 7, starts nothing: no strobe moves and the bus stays undriven.
- R2: Kind codes are 0 = opcode fetch, 1 = memory read, 2 = memory write, 3 = IO read and 4 = IO write. An opcode fetch lasts 4 T-states, or 6 T-states when the long-fetch flag is set. Every other kind lasts 3 T-states.
- R3: The address latch strobe is high from the falling edge that starts T1 until the following rising edge, and low at every other time.
- R4: From T1 on, the select and status pins are set as follows. Opcode fetch: io_m=0, s1=1, s0=1. Memory read: 0,1,0. Memory write: 0,0,1. IO read: 1,1,0. IO write: 1,0,1.
- R5: During T1 the bus is driven with the low address byte and the high byte appears on addr_hi. For IO kinds both carry the low byte of the requested address, which is the port number.
- R6: For fetch and read kinds, rd_n is low for exactly T2. The byte on the bus at the end of T2, when rd_n rises, is returned on rdata.
- R7: For write kinds, wr_n is low for exactly T2. The write byte is driven on the bus through T2 and T3, so it stays valid past the rising edge of wr_n.
- R8: The bus is undriven during T2 and T3 of fetch and read kinds, during T4 to T6 of a fetch, and whenever no cycle runs.
- R9: After a cycle ends, io_m, s1, s0 and addr_hi keep their values until the next request is taken.
- R10: done goes high for exactly one clock, starting at the falling edge that ends the last T-state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each T-state starts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Address, or port number in bits 7:0 |
| req_wdata | input | 8 | Byte to write |
| req_long | input | 1 | Select the 6-state opcode fetch |
| ad_i | input | 8 | Value on the shared bus pins |
| ad_o | output | 8 | Value driven on the shared bus pins |
| ad_oe | output | 1 | Output enable for the shared bus |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | High for IO, low for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rdata | output | 8 | Byte captured by a read or fetch |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench accepts a request on a falling edge and then samples one nanosecond after each later edge. In the first half of T1 it expects the latch strobe high with the address and status valid. After the rising edge in mid T1 it expects the strobe low. On each of the next falling edges it expects the strobe and bus-enable pattern of T2, T3 and any internal states. The done pulse and the captured byte are due on the falling edge after the last T-state, and done must be low again one clock later. The read byte is placed on the bus only during T2 and replaced by its complement in T3, so a capture one edge early or late shows up as a mismatch. All five kinds are swept over eight addresses, with both fetch lengths, plus undefined codes and requests made while a cycle runs.

// File: rtl/bus_cyc_pkg.sv
package bus_cyc_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_1    = 3'd1,
    TS_2    = 3'd2,
    TS_3    = 3'd3,
    TS_4    = 3'd4,
    TS_5    = 3'd5,
    TS_6    = 3'd6
  } tstate_e;

  function automatic logic kind_valid(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic kind_io(input logic [2:0] k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  function automatic logic kind_wr(input logic [2:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic kind_rd(input logic [2:0] k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

endpackage

// File: rtl/bus_cyc_fsm.sv
module bus_cyc_fsm
  import bus_cyc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic          req_long,
  output tstate_e       state_o,
  output tstate_e       nxt_o,
  output logic          accept_o,
  output logic [2:0]    kind_o,
  output logic          done_o
);

  tstate_e     state_q, state_d;
  logic [2:0]  kind_q;
  logic        long_q;
  logic        done_q;
  logic        last_c;
  logic        accept_c;

  always_comb begin
    state_d  = state_q;
    last_c   = 1'b0;
    accept_c = 1'b0;
    case (state_q)
      TS_IDLE: begin
        if (req_valid && kind_valid(req_kind)) begin
          state_d  = TS_1;
          accept_c = 1'b1;
        end
      end
      TS_1: state_d = TS_2;
      TS_2: state_d = TS_3;
      TS_3: begin
        if (kind_q == K_FETCH) begin
          state_d = TS_4;
        end else begin
          state_d = TS_IDLE;
          last_c  = 1'b1;
        end
      end
      TS_4: begin
        if (long_q) begin
          state_d = TS_5;
        end else begin
          state_d = TS_IDLE;
          last_c  = 1'b1;
        end
      end
      TS_5: state_d = TS_6;
      TS_6: begin
        state_d = TS_IDLE;
        last_c  = 1'b1;
      end
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      kind_q  <= 3'd0;
      long_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= last_c;
      if (accept_c) begin
        kind_q <= req_kind;
        long_q <= req_long;
      end
    end
  end

  assign state_o  = state_q;
  assign nxt_o    = state_d;
  assign accept_o = accept_c;
  assign kind_o   = kind_q;
  assign done_o   = done_q;

  // R10: the end pulse never lasts two clocks
  a_r10_done_single: assert property (@(negedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R1: a running cycle is never restarted
  a_r1_no_restart: assert property (@(negedge clk) disable iff (!rst_n)
    (state_q != TS_IDLE) |=> (state_q != TS_1) || ($past(state_q) == TS_IDLE));

endmodule

// File: rtl/bus_cyc_ale.sv
module bus_cyc_ale (
  input  logic clk,
  input  logic rst_n,
  input  logic in_t1,
  input  logic rd_n,
  input  logic wr_n,
  output logic ale
);

  logic mid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= 1'b0;
    end else begin
      mid_q <= in_t1;
    end
  end

  assign ale = in_t1 & ~mid_q;

  // R3: the strobe covers only the first half of T1
  a_r3_ale_half: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R3: the strobe never overlaps a data strobe
  a_r3_ale_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

endmodule

// File: rtl/bus_cyc_drive.sv
module bus_cyc_drive
  import bus_cyc_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  tstate_e       state,
  input  tstate_e       nxt,
  input  logic [2:0]    kind_q,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic [DW-1:0] addr_hi,
  output logic          rd_n,
  output logic          wr_n,
  output logic          io_m,
  output logic          s1,
  output logic          s0,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] ad_o_q, ad_o_d;
  logic          oe_q, oe_d;
  logic [DW-1:0] hi_q, hi_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          rd_n_q, rd_n_d;
  logic          wr_n_q, wr_n_d;
  logic          io_q, io_d;
  logic          s1_q, s1_d;
  logic          s0_q, s0_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic [2:0]    kind_sel;
  logic          in_data;

  always_comb begin
    kind_sel = accept ? req_kind : kind_q;
    in_data  = (nxt == TS_2) || (nxt == TS_3);

    hi_d    = hi_q;
    wdata_d = wdata_q;
    io_d    = io_q;
    s1_d    = s1_q;
    s0_d    = s0_q;
    ad_o_d  = wdata_q;
    if (accept) begin
      io_d    = kind_io(req_kind);
      s1_d    = kind_rd(req_kind);
      s0_d    = (req_kind == K_FETCH) || kind_wr(req_kind);
      hi_d    = kind_io(req_kind) ? req_addr[DW-1:0] : req_addr[AW-1:DW];
      wdata_d = req_wdata;
      ad_o_d  = req_addr[DW-1:0];
    end

    oe_d   = accept || (kind_wr(kind_sel) && in_data);
    rd_n_d = !((nxt == TS_2) && kind_rd(kind_sel));
    wr_n_d = !((nxt == TS_2) && kind_wr(kind_sel));

    rdata_d = rdata_q;
    if ((state == TS_2) && kind_rd(kind_q)) begin
      rdata_d = ad_i;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_o_q  <= '0;
      oe_q    <= 1'b0;
      hi_q    <= '0;
      wdata_q <= '0;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      io_q    <= 1'b0;
      s1_q    <= 1'b0;
      s0_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      ad_o_q  <= ad_o_d;
      oe_q    <= oe_d;
      hi_q    <= hi_d;
      wdata_q <= wdata_d;
      rd_n_q  <= rd_n_d;
      wr_n_q  <= wr_n_d;
      io_q    <= io_d;
      s1_q    <= s1_d;
      s0_q    <= s0_d;
      rdata_q <= rdata_d;
    end
  end

  assign ad_o    = ad_o_q;
  assign ad_oe   = oe_q;
  assign addr_hi = hi_q;
  assign rd_n    = rd_n_q;
  assign wr_n    = wr_n_q;
  assign io_m    = io_q;
  assign s1      = s1_q;
  assign s0      = s0_q;
  assign rdata   = rdata_q;

  // R6: read strobe low for a single T-state
  a_r6_rd_one_state: assert property (@(negedge clk) disable iff (!rst_n)
    !rd_n_q |=> rd_n_q);

  // R7: write strobe low for a single T-state
  a_r7_wr_one_state: assert property (@(negedge clk) disable iff (!rst_n)
    !wr_n_q |=> wr_n_q);

  // R7: write data stays driven through the state after the strobe
  a_r7_hold_after_wr: assert property (@(negedge clk) disable iff (!rst_n)
    !wr_n_q |=> oe_q);

  // R8: no bus drive while memory answers a read
  a_r8_float_on_read: assert property (@(negedge clk) disable iff (!rst_n)
    !rd_n_q |-> !oe_q);

  // R6/R7: strobes are exclusive
  a_r6_strobe_excl: assert property (@(negedge clk) disable iff (!rst_n)
    rd_n_q || wr_n_q);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_cyc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        req_long,
  input  logic [7:0]  ad_i,
  output logic [7:0]  ad_o,
  output logic        ad_oe,
  output logic [7:0]  addr_hi,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n,
  output logic        io_m,
  output logic        s1,
  output logic        s0,
  output logic [7:0]  rdata,
  output logic        done
);

  localparam int DW = 8;

  tstate_e    state, nxt;
  logic       accept;
  logic [2:0] kind_q;

  bus_cyc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_long  (req_long),
    .state_o   (state),
    .nxt_o     (nxt),
    .accept_o  (accept),
    .kind_o    (kind_q),
    .done_o    (done)
  );

  bus_cyc_drive #(.DW(DW)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .state     (state),
    .nxt       (nxt),
    .kind_q    (kind_q),
    .ad_i      (ad_i),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .addr_hi   (addr_hi),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_m      (io_m),
    .s1        (s1),
    .s0        (s0),
    .rdata     (rdata)
  );

  bus_cyc_ale u_ale (
    .clk   (clk),
    .rst_n (rst_n),
    .in_t1 (state == TS_1),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .ale   (ale)
  );

endmodule

// File: tb/bus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_long;
  logic [7:0]  ad_i;
  logic [7:0]  ad_o;
  logic        ad_oe;
  logic [7:0]  addr_hi;
  logic        ale, rd_n, wr_n, io_m, s1, s0, done;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  logic e_io = 1'b0, e_s1 = 1'b0, e_s0 = 1'b0;
  logic [7:0] e_hi = 8'h00;

  always #2 clk = ~clk;

  bus_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_long(req_long),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0),
    .rdata(rdata), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_status(input string req);
    chk(req, "io_m", {15'd0, io_m}, {15'd0, e_io});
    chk(req, "s1", {15'd0, s1}, {15'd0, e_s1});
    chk(req, "s0", {15'd0, s0}, {15'd0, e_s0});
    chk(req, "addr_hi", {8'd0, addr_hi}, {8'd0, e_hi});
  endtask

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input logic lng,
                           input logic [7:0] rb, input logic poke);
    logic is_io, is_wr, is_rd;
    int n_int;
    is_io = (k == 3'd3) || (k == 3'd4);
    is_wr = (k == 3'd2) || (k == 3'd4);
    is_rd = !is_wr;
    n_int = (k == 3'd0) ? (lng ? 3 : 1) : 0;
    e_io = is_io;
    e_s1 = is_rd;
    e_s0 = (k == 3'd0) || is_wr;
    e_hi = is_io ? a[7:0] : a[15:8];

    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; req_long = lng;
    ad_i = 8'h00;
    @(negedge clk); #1;                        // T1, first half
    req_valid = 1'b0;
    chk("R3", "ale in T1", {15'd0, ale}, 16'd1);
    chk("R5", "oe in T1", {15'd0, ad_oe}, 16'd1);
    chk("R5", "low addr", {8'd0, ad_o}, {8'd0, a[7:0]});
    chk_status("R4");
    chk("R10", "done in T1", {15'd0, done}, 16'd0);
    @(posedge clk); #1;                        // T1, second half
    chk("R3", "ale mid T1", {15'd0, ale}, 16'd0);
    @(negedge clk); #1;                        // T2
    if (poke) begin
      req_valid = 1'b1; req_kind = 3'd1;
    end
    chk(is_rd ? "R6" : "R7", "rd_n T2", {15'd0, rd_n}, {15'd0, !is_rd});
    chk(is_rd ? "R6" : "R7", "wr_n T2", {15'd0, wr_n}, {15'd0, !is_wr});
    chk(is_rd ? "R8" : "R7", "oe T2", {15'd0, ad_oe}, {15'd0, is_wr});
    if (is_wr) chk("R7", "wdata T2", {8'd0, ad_o}, {8'd0, wd});
    ad_i = rb;
    @(negedge clk); #1;                        // T3
    ad_i = ~rb;
    chk("R6", "rd_n T3", {15'd0, rd_n}, 16'd1);
    chk("R7", "wr_n T3", {15'd0, wr_n}, 16'd1);
    chk(is_rd ? "R8" : "R7", "oe T3", {15'd0, ad_oe}, {15'd0, is_wr});
    if (is_wr) chk("R7", "wdata T3", {8'd0, ad_o}, {8'd0, wd});
    chk("R2", "done T3", {15'd0, done}, 16'd0);
    for (int i = 0; i < n_int; i++) begin      // internal fetch states
      @(negedge clk); #1;
      if (i == 0) req_valid = 1'b0;
      chk("R8", "oe internal", {15'd0, ad_oe}, 16'd0);
      chk("R2", "done internal", {15'd0, done}, 16'd0);
    end
    req_valid = 1'b0;
    @(negedge clk); #1;                        // end of last T-state
    chk("R2", "done at end", {15'd0, done}, 16'd1);
    chk("R8", "oe idle", {15'd0, ad_oe}, 16'd0);
    if (is_rd) chk("R6", "rdata", {8'd0, rdata}, {8'd0, rb});
    chk_status("R9");
    @(negedge clk); #1;
    chk("R10", "done one clock", {15'd0, done}, 16'd0);
    chk("R1", "no restart ale", {15'd0, ale}, 16'd0);
    chk("R1", "no restart rd_n", {15'd0, rd_n}, 16'd1);
    chk_status("R9");
  endtask

  task automatic try_bad(input logic [2:0] k);
    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = k; req_addr = 16'hBEEF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R1", "bad code ale", {15'd0, ale}, 16'd0);
      chk("R1", "bad code oe", {15'd0, ad_oe}, 16'd0);
      chk("R1", "bad code strobes", {14'd0, rd_n, wr_n}, 16'd3);
    end
    req_valid = 1'b0;
    chk_status("R9");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = 16'h0;
    req_wdata = 8'h0; req_long = 1'b0; ad_i = 8'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "reset oe", {15'd0, ad_oe}, 16'd0);
    chk("R3", "reset ale", {15'd0, ale}, 16'd0);
    chk("R6", "reset strobes", {14'd0, rd_n, wr_n}, 16'd3);
    chk("R10", "reset done", {15'd0, done}, 16'd0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      for (int a = 0; a < 8; a++) begin
        run_cycle(3'(k), 16'(a * 16'h2493) ^ 16'(k * 16'h0101),
                  8'(8'hA5 ^ (a * 17)), a[0], 8'(8'h3C + a * 29), a == 3);
      end
      try_bad(3'd5 + 3'(k % 3));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule